// File: doc/BRIEF.md
# Tiled Chroma Presence Classifier

This block watches a raster stream of YCbCr 4:4:4 pixels and decides, tile by tile, whether a frame holds enough skin-coloured area to count. The frame of 640 by 480 active pixels is cut into an 8 by 8 grid of tiles, each 80 pixels wide and 60 lines tall. Every valid pixel is tested against a programmable chroma window: a lower and an upper bound on Cb and on Cr. Luma plays no part in the decision. Pixels that fall inside the window add to a saturating counter that belongs to the pixel's tile. A one-cycle debug output shows the per-pixel decision.

A frame starts with the valid pixel at column 0, line 0, which clears every tile counter. It ends with a valid pixel that carries the end-of-frame marker. During the vertical blanking that follows, a sequencer visits the 64 tiles, one per clock. For each tile it writes a presence flag into a double-buffered flag memory, together with the tile's column and row. The flag is set when the tile's count reaches the programmed hit threshold. When the last tile has been written, the buffers swap and a done pulse is raised. A downstream reader that addresses the memory therefore always sees one complete frame.

Top module: `skin_tile_map`

## Requirements
- R1: `pix_skin` is 1 in the cycle after a cycle with `pix_valid`=1 and `cb_lo`<=`pix_cb`<=`cb_hi` and `cr_lo`<=`pix_cr`<=`cr_hi` (unsigned, both bounds inclusive). Otherwise it is 0, including after cycles with `pix_valid`=0.
- R2: `pix_luma` has no effect on `pix_skin` or on any tile count.
- R3: A pixel at (x, y) belongs to the tile with column x/80 and row y/60, using integer division. The tile's read address is row*8+column.
- R4: After a frame, a tile's flag is 1 exactly when its count of in-window valid pixels is at least the 13-bit `hit_thresh` captured at the end-of-frame pixel. A threshold of 0 sets every flag.
- R5: The valid pixel at x=0, y=0 starts a frame and clears all tile counts. That pixel is then counted itself. Counts from an earlier frame never carry over.
- R6: A tile count saturates at 8191 and never wraps.
- R7: The valid end-of-frame pixel captured at clock edge k leads to 64 flag writes, one per clock. `wb_done` goes high for exactly one cycle, after edge k+65.
- R8: Until `wb_done` rises, the read port shows the previous complete frame, unchanged by the writes in progress. From that cycle on, it shows the new frame.
- R9: Each entry that has been written returns `rd_col`=`rd_addr[2:0]` and `rd_row`=`rd_addr[5:3]` along with its flag.
- R10: After reset, every read entry returns flag, column and row as 0, and `pix_skin` and `wb_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_valid | input | 1 | Pixel qualifier |
| pix_x | input | 10 | Pixel column |
| pix_y | input | 9 | Pixel line |
| pix_eof | input | 1 | Marks the last pixel of a frame |
| pix_luma | input | 8 | Luma sample (unused by the decision) |
| pix_cb | input | 8 | Blue-difference chroma |
| pix_cr | input | 8 | Red-difference chroma |
| cb_lo | input | 8 | Lower Cb bound, inclusive |
| cb_hi | input | 8 | Upper Cb bound, inclusive |
| cr_lo | input | 8 | Lower Cr bound, inclusive |
| cr_hi | input | 8 | Upper Cr bound, inclusive |
| hit_thresh | input | 13 | Pixels needed to flag a tile |
| rd_addr | input | 6 | Flag memory read address, row*8+column |
| rd_flag | output | 1 | Presence flag of the addressed tile |
| rd_col | output | 3 | Stored tile column |
| rd_row | output | 3 | Stored tile row |
| pix_skin | output | 1 | Registered per-pixel window decision |
| wb_done | output | 1 | One-cycle pulse when a frame's flags are committed |

## Verification
Wrong internal state shows up at the ports in different ways and at different times:

- A fault in the chroma comparators appears on `pix_skin` one cycle after the pixel.
- A fault in tile indexing, counter clearing or saturation stays hidden until the end of the frame. It then shows as a wrong flag at a specific read address, which makes boundary pixels at x=79/80, the right edge and a 4800+ hit burst the decisive stimuli.
- A sequencer or buffer-swap fault shows as a `wb_done` pulse at the wrong cycle or of the wrong width.
- A buffer-swap fault can also show as the read port changing while the walk is still running.

// File: rtl/skin_tile_pkg.sv
package skin_tile_pkg;

   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_WALK = 1'b1
   } seq_state_e;

   function automatic int unsigned bits_for(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

   function automatic bit is_pow2(input int unsigned n);
      return (n != 0) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/skin_chroma_window.sv
module skin_chroma_window #(
   parameter int CW = 8
) (
   input  logic [CW-1:0] cb,
   input  logic [CW-1:0] cr,
   input  logic [CW-1:0] cb_lo,
   input  logic [CW-1:0] cb_hi,
   input  logic [CW-1:0] cr_lo,
   input  logic [CW-1:0] cr_hi,
   output logic          hit
);
   logic cb_in;
   logic cr_in;

   // inclusive unsigned range tests, one per chroma axis
   assign cb_in = (cb >= cb_lo) && (cb <= cb_hi);
   assign cr_in = (cr >= cr_lo) && (cr <= cr_hi);
   assign hit   = cb_in & cr_in;

endmodule

// File: rtl/skin_tile_locator.sv
module skin_tile_locator #(
   parameter int PW    = 10,
   parameter int STEP  = 80,
   parameter int COUNT = 8,
   parameter int IW    = 3
) (
   input  logic [PW-1:0] pos,
   output logic [IW-1:0] idx
);
   // comparator ladder: one boundary test per tile edge, no divider
   logic [COUNT-1:0] past_edge;

   assign past_edge[0] = 1'b0;

   genvar k;
   generate
      for (k = 1; k < COUNT; k++) begin : g_edge
         assign past_edge[k] = (pos >= PW'(k * STEP));
      end
   endgenerate

   always_comb begin
      idx = '0;
      for (int e = 0; e < COUNT; e++) begin
         idx = idx + IW'(past_edge[e]);
      end
   end

endmodule

// File: rtl/skin_tile_counters.sv
module skin_tile_counters
   import skin_tile_pkg::*;
#(
   parameter int GRID_X = 8,
   parameter int GRID_Y = 8,
   parameter int CNTW   = 13,
   parameter int CB     = 3,
   parameter int RB     = 3,
   parameter int AW     = CB + RB
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            px_valid,
   input  logic            px_sof,
   input  logic            px_eof,
   input  logic            px_skin,
   input  logic [AW-1:0]   px_tile,
   input  logic [CNTW-1:0] thresh,
   output logic            wr_en,
   output logic [AW-1:0]   wr_addr,
   output logic            wr_flag,
   output logic [CB-1:0]   wr_col,
   output logic [RB-1:0]   wr_row,
   output logic            wr_last,
   output logic            done
);
   localparam int            GRID_N  = GRID_X * GRID_Y;
   localparam logic [CNTW-1:0] CNT_MAX = {CNTW{1'b1}};
   localparam logic [AW-1:0]   LAST    = AW'(GRID_N - 1);

   logic [GRID_N-1:0][CNTW-1:0] cnt_vec;

   genvar g;
   generate
      for (g = 0; g < GRID_N; g++) begin : g_tile
         logic            mine;
         logic [CNTW-1:0] cnt_q;

         assign mine = px_skin && (px_tile == AW'(g));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (px_valid) begin
               if (px_sof) begin
                  cnt_q <= mine ? CNTW'(1) : '0;
               end else if (mine && (cnt_q != CNT_MAX)) begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
         end

         assign cnt_vec[g] = cnt_q;

         // R6: a full counter stays full
         a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
            (px_valid && !px_sof && mine && (cnt_q == CNT_MAX)) |=> (cnt_q == CNT_MAX));

         // R5: frame start wipes the count
         a_r5_sof_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (px_valid && px_sof && !mine) |=> (cnt_q == '0));
      end
   endgenerate

   seq_state_e      state_q;
   logic [AW-1:0]   idx_q;
   logic [CNTW-1:0] thr_q;
   logic            done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         idx_q   <= '0;
         thr_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            SEQ_IDLE: begin
               if (px_valid && px_eof) begin
                  state_q <= SEQ_WALK;
                  idx_q   <= '0;
                  thr_q   <= thresh;
               end
            end
            SEQ_WALK: begin
               if (idx_q == LAST) begin
                  state_q <= SEQ_IDLE;
                  done_q  <= 1'b1;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   assign wr_en   = (state_q == SEQ_WALK);
   assign wr_addr = idx_q;
   assign wr_flag = (cnt_vec[idx_q] >= thr_q);
   assign wr_col  = idx_q[CB-1:0];
   assign wr_row  = idx_q[AW-1:CB];
   assign wr_last = wr_en && (idx_q == LAST);
   assign done    = done_q;

   // R7: done lasts one cycle
   a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7: the walk advances one tile per clock
   a_r7_walk_step: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_last) |=> (wr_en && (wr_addr == $past(wr_addr) + 1'b1)));

endmodule

// File: rtl/skin_flag_store.sv
module skin_flag_store #(
   parameter int GRID_N = 64,
   parameter int AW     = 6,
   parameter int EW     = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          wr_last,
   input  logic [AW-1:0] wr_addr,
   input  logic [EW-1:0] wr_entry,
   input  logic [AW-1:0] rd_addr,
   output logic [EW-1:0] rd_entry
);
   logic                           front_q;
   logic [1:0][GRID_N-1:0][EW-1:0] bank_vec;

   genvar b;
   generate
      for (b = 0; b < 2; b++) begin : g_bank
         logic [GRID_N-1:0][EW-1:0] mem_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               mem_q <= '0;
            end else if (wr_en && (front_q != 1'(b))) begin
               mem_q[wr_addr] <= wr_entry;
            end
         end

         assign bank_vec[b] = mem_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         front_q <= 1'b0;
      end else if (wr_en && wr_last) begin
         front_q <= ~front_q;
      end
   end

   assign rd_entry = bank_vec[front_q][rd_addr];

   // R8: the reader's bank only changes by a swap
   a_r8_front_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_last) |=> $stable(front_q));

   a_r8_front_untouched: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_last) |=> (bank_vec[front_q] == $past(bank_vec[front_q])));

endmodule

// File: rtl/skin_tile_map.sv
module skin_tile_map
   import skin_tile_pkg::*;
#(
   parameter int FRAME_W = 640,
   parameter int FRAME_H = 480,
   parameter int TILE_W  = 80,
   parameter int TILE_H  = 60,
   parameter int CW      = 8,
   parameter int CNTW    = 13,
   parameter int XW      = bits_for(FRAME_W),
   parameter int YW      = bits_for(FRAME_H),
   parameter int CB      = bits_for(FRAME_W / TILE_W),
   parameter int RB      = bits_for(FRAME_H / TILE_H),
   parameter int AW      = CB + RB
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            pix_valid,
   input  logic [XW-1:0]   pix_x,
   input  logic [YW-1:0]   pix_y,
   input  logic            pix_eof,
   input  logic [CW-1:0]   pix_luma,
   input  logic [CW-1:0]   pix_cb,
   input  logic [CW-1:0]   pix_cr,
   input  logic [CW-1:0]   cb_lo,
   input  logic [CW-1:0]   cb_hi,
   input  logic [CW-1:0]   cr_lo,
   input  logic [CW-1:0]   cr_hi,
   input  logic [CNTW-1:0] hit_thresh,
   input  logic [AW-1:0]   rd_addr,
   output logic            rd_flag,
   output logic [CB-1:0]   rd_col,
   output logic [RB-1:0]   rd_row,
   output logic            pix_skin,
   output logic            wb_done
);
   localparam int GRID_X = FRAME_W / TILE_W;
   localparam int GRID_Y = FRAME_H / TILE_H;
   localparam int GRID_N = GRID_X * GRID_Y;
   localparam int EW     = 1 + RB + CB;

   generate
      if ((FRAME_W % TILE_W) != 0 || (FRAME_H % TILE_H) != 0) begin : g_bad_tiling
         $error("frame size must be a whole number of tiles");
      end
      if (!is_pow2(GRID_X) || !is_pow2(GRID_Y)) begin : g_bad_grid
         $error("tile grid sides must be powers of two");
      end
      if (GRID_X < 2 || GRID_Y < 2) begin : g_small_grid
         $error("tile grid needs at least two tiles per side");
      end
      if ((1 << CNTW) <= TILE_W * TILE_H) begin : g_narrow_cnt
         $error("counter too narrow for one tile");
      end
   endgenerate

   // luma is deliberately not part of the decision
   logic luma_unused;
   assign luma_unused = ^pix_luma;

   logic          hit;
   logic [CB-1:0] col;
   logic [RB-1:0] row;

   skin_chroma_window #(.CW(CW)) u_window (
      .cb(pix_cb), .cr(pix_cr),
      .cb_lo(cb_lo), .cb_hi(cb_hi), .cr_lo(cr_lo), .cr_hi(cr_hi),
      .hit(hit)
   );

   skin_tile_locator #(.PW(XW), .STEP(TILE_W), .COUNT(GRID_X), .IW(CB)) u_col (
      .pos(pix_x), .idx(col)
   );

   skin_tile_locator #(.PW(YW), .STEP(TILE_H), .COUNT(GRID_Y), .IW(RB)) u_row (
      .pos(pix_y), .idx(row)
   );

   logic          s1_valid;
   logic          s1_sof;
   logic          s1_eof;
   logic          s1_skin;
   logic [AW-1:0] s1_tile;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_sof   <= 1'b0;
         s1_eof   <= 1'b0;
         s1_skin  <= 1'b0;
         s1_tile  <= '0;
      end else begin
         s1_valid <= pix_valid;
         s1_sof   <= pix_valid && (pix_x == '0) && (pix_y == '0);
         s1_eof   <= pix_valid && pix_eof;
         s1_skin  <= pix_valid && hit;
         s1_tile  <= {row, col};
      end
   end

   assign pix_skin = s1_skin;

   logic          wr_en;
   logic          wr_last;
   logic          wr_flag;
   logic [AW-1:0] wr_addr;
   logic [CB-1:0] wr_col;
   logic [RB-1:0] wr_row;
   logic [EW-1:0] rd_entry;

   skin_tile_counters #(
      .GRID_X(GRID_X), .GRID_Y(GRID_Y), .CNTW(CNTW), .CB(CB), .RB(RB), .AW(AW)
   ) u_count (
      .clk(clk), .rst_n(rst_n),
      .px_valid(s1_valid), .px_sof(s1_sof), .px_eof(s1_eof),
      .px_skin(s1_skin), .px_tile(s1_tile), .thresh(hit_thresh),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_flag(wr_flag),
      .wr_col(wr_col), .wr_row(wr_row), .wr_last(wr_last), .done(wb_done)
   );

   skin_flag_store #(.GRID_N(GRID_N), .AW(AW), .EW(EW)) u_store (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_last(wr_last), .wr_addr(wr_addr),
      .wr_entry({wr_flag, wr_row, wr_col}),
      .rd_addr(rd_addr), .rd_entry(rd_entry)
   );

   assign rd_flag = rd_entry[EW-1];
   assign rd_row  = rd_entry[CB +: RB];
   assign rd_col  = rd_entry[CB-1:0];

   // R1: a detection is always preceded by a valid pixel
   a_r1_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      pix_skin |-> $past(pix_valid));

   // R7: completion only follows an active write walk
   a_r7_done_after_walk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_done |-> $past(wr_en && wr_last));

endmodule

// File: tb/tb_skin_tile_map.sv
module tb_skin_tile_map;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pix_valid = 1'b0;
   logic [9:0]  pix_x = '0;
   logic [8:0]  pix_y = '0;
   logic        pix_eof = 1'b0;
   logic [7:0]  pix_luma = '0;
   logic [7:0]  pix_cb = '0;
   logic [7:0]  pix_cr = '0;
   logic [7:0]  cb_lo = 8'd100;
   logic [7:0]  cb_hi = 8'd150;
   logic [7:0]  cr_lo = 8'd130;
   logic [7:0]  cr_hi = 8'd170;
   logic [12:0] hit_thresh = 13'd3;
   logic [5:0]  rd_addr = '0;
   logic        rd_flag;
   logic [2:0]  rd_col;
   logic [2:0]  rd_row;
   logic        pix_skin;
   logic        wb_done;

   skin_tile_map dut (
      .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_x(pix_x), .pix_y(pix_y),
      .pix_eof(pix_eof), .pix_luma(pix_luma), .pix_cb(pix_cb), .pix_cr(pix_cr),
      .cb_lo(cb_lo), .cb_hi(cb_hi), .cr_lo(cr_lo), .cr_hi(cr_hi),
      .hit_thresh(hit_thresh), .rd_addr(rd_addr), .rd_flag(rd_flag),
      .rd_col(rd_col), .rd_row(rd_row), .pix_skin(pix_skin), .wb_done(wb_done)
   );

   always #10 clk = ~clk;

   int n_cmp = 0;
   int n_bad = 0;

   bit exp_q[$];
   int cnt_model [64];
   bit front_exp [64];
   bit front_written = 1'b0;
   bit new_exp   [64];
   int thr_model = 0;

   task automatic check(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // monitor: compares the per-pixel decision one edge after each driven item
   always @(posedge clk) begin
      #1;
      if (exp_q.size() > 0) begin
         bit e;
         e = exp_q.pop_front();
         check("R1/R2 pix_skin", int'(pix_skin), int'(e));
      end
   end

   function automatic bit in_win(input int cb, input int cr);
      return (cb >= cb_lo) && (cb <= cb_hi) && (cr >= cr_lo) && (cr <= cr_hi);
   endfunction

   // driver: applies one pixel, predicts its decision and the tile model
   task automatic drive_px(input int x, input int y, input int luma, input int cb,
                           input int cr, input bit valid, input bit eof);
      bit s;
      @(negedge clk);
      pix_valid = valid; pix_x = 10'(x); pix_y = 9'(y); pix_eof = eof;
      pix_luma = 8'(luma); pix_cb = 8'(cb); pix_cr = 8'(cr);
      s = valid && in_win(cb, cr);
      exp_q.push_back(s);
      if (valid) begin
         if (x == 0 && y == 0) begin
            for (int t = 0; t < 64; t++) cnt_model[t] = 0;
         end
         if (s) begin
            int t;
            t = (y / 60) * 8 + (x / 80);
            if (cnt_model[t] < 8191) cnt_model[t]++;
         end
         if (eof) begin
            thr_model = int'(hit_thresh);
            for (int t = 0; t < 64; t++) new_exp[t] = (cnt_model[t] >= thr_model);
         end
      end
   endtask

   task automatic check_map(input string tag);
      for (int a = 0; a < 64; a++) begin
         rd_addr = 6'(a);
         #1;
         check({tag, " R4/R3 flag"}, int'(rd_flag), int'(front_exp[a]));
         check("R9 col", int'(rd_col), front_written ? (a % 8) : 0);
         check("R9 row", int'(rd_row), front_written ? (a / 8) : 0);
      end
   endtask

   // called right after the eof pixel was driven: times done, probes old frame
   task automatic finish_frame(input int probe);
      int lat;
      bit seen;
      lat = 0; seen = 1'b0;
      while (!seen && lat < 200) begin
         @(posedge clk);
         #2;
         pix_valid = 1'b0; pix_eof = 1'b0;
         lat++;
         if (lat == 3) begin
            rd_addr = 6'(probe);
            #1;
            check("R8 old frame during walk", int'(rd_flag), int'(front_exp[probe]));
         end
         if (wb_done) seen = 1'b1;
      end
      check("R7 done latency", lat, 66);
      @(posedge clk);
      #2;
      check("R7 done one cycle", int'(wb_done), 0);
      for (int t = 0; t < 64; t++) front_exp[t] = new_exp[t];
      front_written = 1'b1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      for (int t = 0; t < 64; t++) begin
         cnt_model[t] = 0; front_exp[t] = 1'b0; new_exp[t] = 1'b0;
      end
      repeat (3) @(posedge clk);
      #2;
      check("R10 pix_skin reset", int'(pix_skin), 0);
      check("R10 wb_done reset", int'(wb_done), 0);
      check_map("R10 reset");
      @(negedge clk);
      rst_n = 1'b1;

      // frame A: threshold 3, window edges, tile edges, invalid pixels
      hit_thresh = 13'd3;
      drive_px(0, 0, 16, 120, 150, 1, 0);       // R5 sof counted, tile 0
      drive_px(10, 5, 255, 100, 130, 1, 0);     // R1 lower bounds inclusive
      drive_px(79, 59, 0, 150, 170, 1, 0);      // R1 upper bounds, R3 col 0 edge
      drive_px(80, 0, 0, 120, 150, 1, 0);       // R3 col 1 starts at 80, R2 luma 0
      drive_px(80, 10, 128, 120, 150, 1, 0);
      drive_px(80, 20, 255, 120, 150, 1, 0);
      drive_px(639, 0, 40, 110, 140, 1, 0);     // R3 right edge, tile 7
      drive_px(639, 1, 40, 110, 140, 1, 0);
      drive_px(639, 2, 40, 110, 140, 1, 0);
      drive_px(160, 60, 50, 120, 150, 1, 0);    // R4 tile 10, one short
      drive_px(170, 119, 50, 120, 150, 1, 0);
      drive_px(300, 200, 90, 99, 150, 1, 0);    // R1 outside each bound
      drive_px(300, 200, 90, 151, 150, 1, 0);
      drive_px(300, 200, 90, 120, 129, 1, 0);
      drive_px(300, 200, 90, 120, 171, 1, 0);
      for (int i = 0; i < 5; i++) drive_px(400, 400, 90, 120, 150, 0, 0); // R1 invalid
      drive_px(639, 479, 30, 120, 150, 1, 1);   // eof, tile 63 gets 1
      finish_frame(1);
      check_map("frame A");

      // frame B: counts must restart (R5), threshold 1
      hit_thresh = 13'd1;
      drive_px(0, 0, 16, 10, 10, 1, 0);
      drive_px(600, 430, 16, 120, 150, 1, 0);
      drive_px(639, 479, 16, 10, 10, 1, 1);
      finish_frame(1);                          // R8 probe sees frame A tile 1 = 1
      check_map("frame B R5");

      // frame C: saturation against the top threshold (R6)
      hit_thresh = 13'd8191;
      drive_px(0, 0, 16, 10, 10, 1, 0);
      for (int i = 0; i < 8195; i++) drive_px(300, 300, 16, 120, 150, 1, 0);
      for (int i = 0; i < 8190; i++) drive_px(400, 300, 16, 120, 150, 1, 0);
      drive_px(639, 479, 16, 10, 10, 1, 1);
      finish_frame(63);                         // frame B tile 63 = 1
      check_map("frame C R6");

      // frame D: threshold 0 flags every tile (R4)
      hit_thresh = 13'd0;
      drive_px(0, 0, 16, 10, 10, 1, 0);
      drive_px(639, 479, 16, 10, 10, 1, 1);
      finish_frame(43);                         // frame C tile 43 = 1
      check_map("frame D R4");

      repeat (3) @(posedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule